// File: doc/BRIEF.md
# Tolerant Preamble Pattern Detector

This block watches a demodulated chip stream for an alternating preamble. Every bit is carried by four chips, so the ideal pattern is four ones, four zeros, four ones and so on. On each valid chip, the block slides a window of one, two or three bytes (32, 64 or 96 chips) over the stream. It counts how many chips in that window disagree with the ideal pattern, and keeps two counts: one for a window that starts on a run of ones and one for a window that starts on a run of zeros. The smaller of the two counts is the window's error figure.

When the window is full and the error figure is at or below a programmed tolerance, the block raises a one-cycle detect pulse. It then stays quiet until the error figure has climbed above the tolerance again, or until the detector is cleared. The detector is cleared by disabling it, by forcing it off from the startup or gain-control sequencer, or by changing the window size. The running error figure is brought out for debug.

Bit synchronisation, demodulation and sync-word matching sit upstream or downstream and are not part of this block. The chip strobe is assumed to be aligned to bit boundaries.

Top module: `preamble_detector`

## Requirements
- R1: After reset, `detIrq` is 0 and `errCount` is 0.
- R2: The window length follows `sizeCode`: 2'b00 gives 32 chips, 2'b01 gives 64 chips, 2'b10 gives 96 chips, and the reserved 2'b11 also gives 96 chips. A detect needs a full window of that length.
- R3: Chip positions are numbered from 0, counting the chips accepted since the last clear. For one reference pattern, the expected chip is 1 when (index/4) is even and 0 otherwise; the other reference pattern is the inverse. After each clock edge, `errCount` is the smaller of the two mismatch counts over the most recent min(accepted chips, window length) chips.
- R4: When the window is full and `errCount` <= `errTol` while the detector is armed, `detIrq` is high for exactly one cycle, on the clock edge after that condition holds.
- R5: After a detect, no further detect occurs until a full window has shown `errCount` > `errTol`, or until a clear.
- R6: While `detEnable` is 0 or `forceOff` is 1, chips are ignored, the history is cleared, `errCount` reads 0 and `detIrq` stays 0. The detector is re-armed.
- R7: A change of `sizeCode` clears the history and re-arms the detector. The chip offered on that same edge is dropped.
- R8: A chip with `chipValid` low is ignored and changes neither `errCount` nor the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| chipValid | input | 1 | Strobe marking a new chip on `chipIn` |
| chipIn | input | 1 | Demodulated chip value |
| detEnable | input | 1 | Detector enable |
| forceOff | input | 1 | Override from the startup/gain sequencer; holds the detector off |
| sizeCode | input | 2 | Window size code (00: 1 byte, 01: 2 bytes, 10/11: 3 bytes) |
| errTol | input | 5 | Number of chip errors tolerated over the window |
| detIrq | output | 1 | One-cycle detect pulse |
| errCount | output | 7 | Current lower-of-two-phases chip error count |

## Verification
Two functions can land on the same clock edge: a clear (from a size change, a disable or a force-off) and the arrival of a chip or the firing of a detect. The random phase of the bench changes the size, enable and force inputs at arbitrary points in a valid chip stream, so a clear regularly coincides with a strobe and with a window that is ready to fire. A bench model lets the clear win: the chip is dropped, the pulse is suppressed and the detector is re-armed. Every cycle, the model's count and pulse are compared with the ports.

// File: rtl/preamble_det_pkg.sv
package preamble_det_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;   // wipe history, counters and phase
    logic shift;   // accept chipIn into the window
  } ctlStrb_t;

  localparam int NUM_PHASES = 2;
  localparam int MAX_BYTES  = 3;

  // Number of bytes selected by a size code (reserved code maps to max)
  function automatic int unsigned bytesOf(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 2;
      default: return MAX_BYTES;
    endcase
  endfunction

endpackage

// File: rtl/pdet_datapath.sv
module pdet_datapath
  import preamble_det_pkg::*;
#(
  parameter int CHIPS_PER_BIT = 4,
  parameter int BITS_PER_BYTE = 8,
  parameter int CNT_W         = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrb_t         strb,
  input  logic [1:0]       sizeQ,
  input  logic             chipIn,
  output logic             winFull,
  output logic [CNT_W-1:0] minErr
);

  localparam int BYTE_CHIPS = CHIPS_PER_BIT * BITS_PER_BYTE;
  localparam int MAX_CHIPS  = MAX_BYTES * BYTE_CHIPS;
  localparam int PH_W       = $clog2(2 * CHIPS_PER_BIT);

  logic [MAX_CHIPS-1:0] shiftReg;
  logic [CNT_W-1:0]     fill;
  logic [CNT_W-1:0]     winLen;
  logic [PH_W-1:0]      phase;
  logic                 leaving;
  logic [CNT_W-1:0]     errVec [NUM_PHASES];

  // Window length in chips for the latched size code
  always_comb begin
    winLen = CNT_W'(bytesOf(sizeQ) * BYTE_CHIPS);
  end

  // Oldest chip in the window; its reference equals the incoming one
  // because the window spans a whole number of pattern periods.
  assign leaving = shiftReg[winLen - CNT_W'(1)];
  assign winFull = (fill == winLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      fill     <= '0;
      phase    <= '0;
    end else if (strb.clear) begin
      shiftReg <= '0;
      fill     <= '0;
      phase    <= '0;
    end else if (strb.shift) begin
      shiftReg <= {shiftReg[MAX_CHIPS-2:0], chipIn};
      phase    <= phase + PH_W'(1);
      if (!winFull) fill <= fill + CNT_W'(1);
    end
  end

  // One mismatch counter per reference phase
  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    logic             refBit;
    logic [CNT_W-1:0] cnt;
    logic             addErr;
    logic             subErr;

    assign refBit = ~phase[PH_W-1] ^ 1'(p);
    assign addErr = chipIn ^ refBit;
    assign subErr = winFull & (leaving ^ refBit);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            cnt <= '0;
      else if (strb.clear)  cnt <= '0;
      else if (strb.shift)  cnt <= cnt + CNT_W'(addErr) - CNT_W'(subErr);
    end

    assign errVec[p] = cnt;
  end

  assign minErr = (errVec[0] <= errVec[1]) ? errVec[0] : errVec[1];

  // Fill never runs past the selected window
  a_r2_fill_cap: assert property (@(posedge clk) disable iff (!rstN)
    fill <= winLen);

  // Each chip counts as an error against exactly one phase
  a_r3_phase_sum: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, errVec[0]} + {1'b0, errVec[1]}) == {1'b0, fill});

  // A clear leaves an empty window behind it
  a_r7_clear_empty: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (fill == '0 && minErr == '0));

endmodule

// File: rtl/pdet_control.sv
module pdet_control
  import preamble_det_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int TOL_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipValid,
  input  logic             detEnable,
  input  logic             forceOff,
  input  logic [1:0]       sizeCode,
  input  logic [TOL_W-1:0] errTol,
  input  logic             winFull,
  input  logic [CNT_W-1:0] minErr,
  output ctlStrb_t         strb,
  output logic [1:0]       sizeQ,
  output logic             detIrq
);

  logic active;
  logic clear;
  logic hit;
  logic armed;

  assign active = detEnable & ~forceOff;
  assign clear  = ~active | (sizeCode != sizeQ);
  assign hit    = winFull && (32'(minErr) <= 32'(errTol));

  always_comb begin
    strb       = '0;
    strb.clear = clear;
    strb.shift = chipValid & ~clear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeQ  <= 2'b01;
      armed  <= 1'b1;
      detIrq <= 1'b0;
    end else if (clear) begin
      sizeQ  <= sizeCode;
      armed  <= 1'b1;
      detIrq <= 1'b0;
    end else if (armed && hit) begin
      armed  <= 1'b0;
      detIrq <= 1'b1;
    end else begin
      detIrq <= 1'b0;
      if (winFull && !hit) armed <= 1'b1;
    end
  end

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    detIrq |=> !detIrq);

  a_r4_fire_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(detIrq) |-> $past(hit));

  a_r6_off_silent: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> !detIrq);

endmodule

// File: rtl/preamble_detector.sv
module preamble_detector
  import preamble_det_pkg::*;
#(
  parameter int CHIPS_PER_BIT = 4,
  parameter int BITS_PER_BYTE = 8,
  parameter int TOL_W         = 5,
  localparam int CNT_W = $clog2(MAX_BYTES * CHIPS_PER_BIT * BITS_PER_BYTE + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipValid,
  input  logic             chipIn,
  input  logic             detEnable,
  input  logic             forceOff,
  input  logic [1:0]       sizeCode,
  input  logic [TOL_W-1:0] errTol,
  output logic             detIrq,
  output logic [CNT_W-1:0] errCount
);

  ctlStrb_t         strb;
  logic [1:0]       sizeQ;
  logic             winFull;
  logic [CNT_W-1:0] minErr;

  pdet_control #(
    .CNT_W(CNT_W),
    .TOL_W(TOL_W)
  ) ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .chipValid(chipValid),
    .detEnable(detEnable),
    .forceOff (forceOff),
    .sizeCode (sizeCode),
    .errTol   (errTol),
    .winFull  (winFull),
    .minErr   (minErr),
    .strb     (strb),
    .sizeQ    (sizeQ),
    .detIrq   (detIrq)
  );

  pdet_datapath #(
    .CHIPS_PER_BIT(CHIPS_PER_BIT),
    .BITS_PER_BYTE(BITS_PER_BYTE),
    .CNT_W        (CNT_W)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .sizeQ  (sizeQ),
    .chipIn (chipIn),
    .winFull(winFull),
    .minErr (minErr)
  );

  assign errCount = minErr;

endmodule

// File: tb/preamble_detector_tb_top.sv
module preamble_detector_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       chipValid = 1'b0;
  logic       chipIn = 1'b0;
  logic       detEnable = 1'b1;
  logic       forceOff = 1'b0;
  logic [1:0] sizeCode = 2'b01;
  logic [4:0] errTol = 5'd10;
  logic       detIrq;
  logic [6:0] errCount;

  always #4 clk = ~clk;   // 125 MHz

  preamble_detector dut_i (
    .clk(clk), .rstN(rstN), .chipValid(chipValid), .chipIn(chipIn),
    .detEnable(detEnable), .forceOff(forceOff), .sizeCode(sizeCode),
    .errTol(errTol), .detIrq(detIrq), .errCount(errCount)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Bench-side configuration driven on each step
  bit       cEn = 1, cFrc = 0;
  bit [1:0] cSz = 2'b01;
  int       cTol = 10;

  // Reference model state
  bit  mq[$];
  int  mTotal = 0;
  bit [1:0] mSizeQ = 2'b01;
  bit  mArmed = 1;
  bit  expIrq = 0;
  int  stepNo = 0;
  int  irqCnt = 0;
  int  firstIrq = -1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (step %0d)", tag, act, exp, stepNo);
    end
  endtask

  function automatic int winOf(input bit [1:0] s);
    return (s == 2'b00) ? 32 : (s == 2'b01) ? 64 : 96;
  endfunction

  function automatic bit patA(input int idx);
    return ((idx / 4) % 2) == 0;
  endfunction

  function automatic int modelFill();
    int w = winOf(mSizeQ);
    return (mq.size() < w) ? mq.size() : w;
  endfunction

  function automatic int modelErr();
    int n = modelFill();
    int eA = 0;
    for (int j = mq.size() - n; j < mq.size(); j++) begin
      int absIdx = mTotal - mq.size() + j;
      if (mq[j] != patA(absIdx)) eA++;
    end
    return (eA <= n - eA) ? eA : n - eA;
  endfunction

  task automatic step(input bit v, input bit c);
    bit act, clr, full;
    int e;
    @(negedge clk);
    chipValid = v; chipIn = c; detEnable = cEn; forceOff = cFrc;
    sizeCode = cSz; errTol = 5'(cTol);
    @(posedge clk);
    act  = cEn && !cFrc;
    clr  = !act || (cSz != mSizeQ);
    full = (modelFill() == winOf(mSizeQ));
    e    = modelErr();
    if (clr) begin
      expIrq = 0; mArmed = 1;
      mq.delete(); mTotal = 0; mSizeQ = cSz;
    end else begin
      if (mArmed && full && e <= cTol) begin
        expIrq = 1; mArmed = 0;
      end else begin
        expIrq = 0;
        if (full && e > cTol) mArmed = 1;
      end
      if (v) begin
        mq.push_back(c); mTotal++;
        if (mq.size() > 96) void'(mq.pop_front());
      end
    end
    stepNo++;
    #1;
    chk("R4 detIrq", int'(detIrq), int'(expIrq));
    chk("R3 errCount", int'(errCount), modelErr());
    if (detIrq) begin
      irqCnt++;
      if (firstIrq < 0) firstIrq = stepNo;
    end
  endtask

  // Clear via disable, then re-enable; history starts at index 0
  task automatic restart(input bit [1:0] s, input int tol);
    cEn = 0; step(0, 0);
    cEn = 1; cSz = s; cTol = tol; step(0, 0);
    irqCnt = 0; firstIrq = -1;
  endtask

  // Feed n chips from index k0; phase inverts; every errEvery-th chip flipped
  task automatic feed(input int k0, input int n, input bit ph, input int errEvery);
    for (int k = k0; k < k0 + n; k++) begin
      bit f = (errEvery > 0) && ((k % errEvery) == errEvery - 1);
      step(1, patA(k) ^ ph ^ f);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base, genIdx, pErr, fires, offLeft;
    void'($urandom(32'h1234_abcd));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset detIrq", int'(detIrq), 0);
    chk("R1 reset errCount", int'(errCount), 0);
    @(negedge clk); rstN = 1;

    // R2/R4: one-byte window, perfect phase A, tolerance 0
    restart(2'b00, 0);
    base = stepNo;
    feed(0, 32, 0, 0);
    step(0, 0);
    chk("R2 first detect after 32 chips", firstIrq - base, 33);
    step(0, 0);
    chk("R4 single pulse", irqCnt, 1);

    // R2: reserved size code uses 96 chips; phase B, 3 errors, tol 3
    restart(2'b11, 3);
    base = stepNo;
    feed(0, 96, 1, 30);
    step(0, 0);
    chk("R2 reserved code window 96", firstIrq - base, 97);
    chk("R3 three errors counted", int'(errCount), 3);

    // R4 boundary: two-byte window, 3 errors, tol 2 -> no detect
    restart(2'b01, 2);
    feed(0, 64, 0, 20);
    step(0, 0);
    chk("R4 over tolerance no detect", irqCnt, 0);
    chk("R3 count at boundary", int'(errCount), 3);
    cTol = 3; step(0, 0);
    chk("R4 raising tolerance fires", irqCnt, 1);

    // R5: no refire on clean stream, refire after exceeding tolerance
    restart(2'b00, 2);
    feed(0, 32, 0, 0);
    feed(32, 64, 0, 0);
    chk("R5 no refire while clean", irqCnt, 1);
    feed(96, 32, 0, 8);
    feed(128, 40, 0, 0);
    chk("R5 refire after exceed", irqCnt, 2);

    // R8: invalid chips ignored
    restart(2'b01, 0);
    feed(0, 20, 0, 0);
    for (int i = 0; i < 10; i++) step(0, 1'(i));
    chk("R8 invalid chips ignored", int'(errCount), 0);
    feed(20, 44, 0, 0);
    step(0, 0);
    chk("R8 detect still at 64 valid chips", irqCnt, 1);

    // R6: force-off clears and blocks
    restart(2'b00, 5);
    feed(0, 20, 0, 3);
    cFrc = 1;
    for (int i = 0; i < 40; i++) step(1, 1'(i));
    chk("R6 forced off count", int'(errCount), 0);
    chk("R6 forced off no irq", irqCnt, 0);
    cFrc = 0;

    // R7: size change clears history
    restart(2'b10, 5);
    feed(0, 30, 0, 4);
    cSz = 2'b00; step(1, 0);
    chk("R7 size change clears", int'(errCount), 0);

    // Random phase with coinciding clears and strobes
    cSz = 2'b01; cTol = 4; cEn = 1; cFrc = 0;
    genIdx = 0; pErr = 2; fires = 0; offLeft = 0; irqCnt = 0;
    for (int it = 0; it < 6000; it++) begin
      bit v, c;
      if (it % 250 == 0) begin
        cTol = $urandom_range(0, 20);
        case ($urandom_range(0, 3))
          0: pErr = 0; 1: pErr = 2; 2: pErr = 6; default: pErr = 40;
        endcase
      end
      if (offLeft > 0) begin
        offLeft--;
        if (offLeft == 0) begin cEn = 1; cFrc = 0; genIdx = 4 * $urandom_range(0, 1); end
      end else if ($urandom_range(0, 999) < 3) begin
        if ($urandom_range(0, 1) == 1) cEn = 0; else cFrc = 1;
        offLeft = $urandom_range(1, 6);
      end else if ($urandom_range(0, 999) < 3) begin
        cSz = 2'($urandom_range(0, 3));
        genIdx = 4 * $urandom_range(0, 1);
      end
      v = ($urandom_range(0, 9) < 8);
      c = patA(genIdx) ^ ($urandom_range(0, 99) < pErr);
      if (v) genIdx++;
      step(v, c);
    end
    fires = irqCnt;
    chk("R4 random detects seen", int'(fires > 0), 1);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule